// File: doc/BRIEF.md
# Round Robin Channel Request Scheduler

This block polls a fixed set of channels in a circular, ascending order and, on each clock cycle, asks one of them for a single unit of data. Each request goes out as a write on a memory-mapped request port. The write address is the channel index multiplied by four, so each channel has its own word-aligned slot, and the write data is always the value one. A downstream agent can stall the port with a wait signal. While that signal is high, the pending write stays on the port unchanged until the agent accepts it.

A status stream marks channels as nearly full or clears that mark. The stream carries a valid strobe, a channel index and a one-bit flag. When the rotation reaches a marked channel, the block issues no write for that cycle, leaves the port idle, and moves on to the next channel. The block does not track whether a request is ever served, and it never sees the data that comes back.

Top module: `rr_req_sched`

## Requirements
- R1: While rst_n is low (asynchronous, active low), req_wr is 0 and every almost-full mark is clear. The first clock edge after rst_n rises issues a write to channel 0 (address 0).
- R2: Whenever req_wr is 1, req_wdata equals 1.
- R3: A write to channel c carries req_addr = 4*c. req_addr is clog2(NUM_CH)+2 bits wide, and its two low bits are 0 while writing.
- R4: With no stall and no marks, one write is issued per cycle, and the channel index rises by one from each cycle to the next.
- R5: After channel NUM_CH-1, the next channel handled is channel 0.
- R6: When the channel whose turn it is carries an almost-full mark, that slot has req_wr = 0. The following slot handles the next channel in order.
- R7: A cycle with req_wr = 1 and req_wait = 1 is a stall. In the next cycle req_wr, req_addr and req_wdata are unchanged, and the rotation does not advance. After the write is accepted, the next slot handles the next channel in order.
- R8: On a clock edge where af_valid = 1, the mark of channel af_chan is set to af_flag (1 sets it, 0 clears it). On edges where af_valid = 0, af_chan and af_flag are ignored.
- R9: The turn of channel c is decided on the clock edge at which c's slot (write or idle) begins. A status update sampled on that same edge does not change that slot. It takes effect from c's next visit onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | output | clog2(NUM_CH)+2 | Request write address, 4 × channel |
| req_wr | output | 1 | Request write strobe |
| req_wdata | output | DATA_W | Requested amount, constant 1 |
| req_wait | input | 1 | Downstream stall; holds the pending write |
| af_valid | input | 1 | Status update strobe |
| af_chan | input | clog2(NUM_CH) | Channel the status update refers to |
| af_flag | input | 1 | 1 marks the channel almost full, 0 clears the mark |

## Verification
A corrupted rotation pointer shows up as a wrong address on the very next accepted write. It can stay hidden for at most one lap when the channels it reaches are all marked. A mark bit that holds the wrong value is visible only when its channel's turn comes: there is a write where an idle slot was due, or the reverse, within NUM_CH slots of the fault. A stall that fails to hold the port shows one cycle after req_wait is seen, as a changed address or a dropped strobe.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

    // byte address step between neighbouring channel slots is 4 = 1 << WORD_SHIFT
    localparam int unsigned WORD_SHIFT = 2;

    typedef enum logic [0:0] {
        SLOT_IDLE  = 1'b0,
        SLOT_WRITE = 1'b1
    } slot_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rr_flag_bank.sv
module rr_flag_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_valid,
    input  logic [CH_W-1:0] upd_chan,
    input  logic            upd_flag,
    input  logic [CH_W-1:0] rd_chan,
    output logic            rd_flag
);

    typedef struct packed {
        logic [NUM_CH-1:0] full;
    } bank_t;

    bank_t st_d, st_q;

    // next state: only the addressed mark changes; out-of-range indexes match nothing
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (upd_valid && (upd_chan == CH_W'(i))) begin
                st_d.full[i] = upd_flag;
            end
        end
    end

    // read port sees the registered marks, so a same-edge update applies later
    always_comb begin
        rd_flag = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_chan == CH_W'(i)) begin
                rd_flag = st_q.full[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rr_ring_ptr.sv
module rr_ring_ptr #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [CH_W-1:0] ptr
);

    localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic [CH_W-1:0] idx;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.idx;

endmodule

// File: rtl/rr_req_issue.sv
module rr_req_issue
    import rr_sched_pkg::*;
#(
    parameter int unsigned CH_W   = 3,
    parameter int unsigned ADDR_W = CH_W + WORD_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decide,
    input  logic [CH_W-1:0]   chan,
    input  logic              blocked,
    output logic              wr,
    output logic [ADDR_W-1:0] addr
);

    typedef struct packed {
        slot_e             slot;
        logic [ADDR_W-1:0] addr;
    } issue_t;

    issue_t st_d, st_q;

    // when not deciding (stall) the whole presented request is held
    always_comb begin
        st_d = st_q;
        if (decide) begin
            st_d.slot = blocked ? SLOT_IDLE : SLOT_WRITE;
            st_d.addr = ADDR_W'(chan) << WORD_SHIFT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= SLOT_IDLE;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr   = (st_q.slot == SLOT_WRITE);
    assign addr = st_q.addr;

endmodule

// File: rtl/rr_req_sched.sv
module rr_req_sched
    import rr_sched_pkg::*;
#(
    parameter  int unsigned NUM_CH = 8,
    parameter  int unsigned DATA_W = 8,
    localparam int unsigned CH_W   = idx_width(NUM_CH),
    localparam int unsigned ADDR_W = CH_W + WORD_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_wr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              req_wait,
    input  logic              af_valid,
    input  logic [CH_W-1:0]   af_chan,
    input  logic              af_flag
);

    logic            stall;
    logic            decide;
    logic [CH_W-1:0] cur_ch;
    logic            cur_full;

    assign stall  = req_wr & req_wait;
    assign decide = ~stall;

    rr_ring_ptr #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (decide),
        .ptr   (cur_ch)
    );

    rr_flag_bank #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (af_valid),
        .upd_chan  (af_chan),
        .upd_flag  (af_flag),
        .rd_chan   (cur_ch),
        .rd_flag   (cur_full)
    );

    rr_req_issue #(
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .decide  (decide),
        .chan    (cur_ch),
        .blocked (cur_full),
        .wr      (req_wr),
        .addr    (req_addr)
    );

    assign req_wdata = DATA_W'(1);

endmodule

// File: rtl/rr_req_sched_chk.sv
module rr_req_sched_chk #(
    parameter  int unsigned NUM_CH = 8,
    parameter  int unsigned DATA_W = 8,
    localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W = CH_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_wr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              req_wait
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(4 * (NUM_CH - 1));

    function automatic logic [ADDR_W-1:0] follow(input logic [ADDR_W-1:0] a);
        return (a == TOP_ADDR) ? '0 : a + ADDR_W'(4);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (!req_wr)
                else $error("req_wr high during reset");
        end
    end

    assert_const_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |-> req_wdata == DATA_W'(1));

    assert_word_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |-> (req_addr[1:0] == 2'b00) && (req_addr <= TOP_ADDR));

    // accepted write is followed by either an idle slot or the next channel (R5 wrap included)
    assert_next_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !req_wait) |=> (!req_wr || (req_addr == follow($past(req_addr)))));

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_wait) |=> (req_wr && $stable(req_addr) && $stable(req_wdata)));

endmodule

bind rr_req_sched rr_req_sched_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .req_wait  (req_wait)
);

// File: tb/rr_req_sched_bench.sv
module rr_req_sched_bench;

    localparam int unsigned N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_addr;
    logic       req_wr;
    logic [7:0] req_wdata;
    logic       req_wait = 1'b0;
    logic       af_valid = 1'b0;
    logic [1:0] af_chan = 2'd0;
    logic       af_flag = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [1:0] mptr = 2'd0;
    logic [3:0] mflags = 4'd0;
    logic       exp_wr = 1'b0;
    logic [3:0] exp_addr = 4'd0;

    always #10 clk = ~clk;

    rr_req_sched #(.NUM_CH(N), .DATA_W(8)) u_rr_req_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .req_wait  (req_wait),
        .af_valid  (af_valid),
        .af_chan   (af_chan),
        .af_flag   (af_flag)
    );

    task automatic compare(input string tag);
        checks++;
        if (req_wr !== exp_wr) begin
            errors++;
            $display("FAIL %s req_wr got %0b exp %0b", tag, req_wr, exp_wr);
        end
        if (exp_wr) begin
            checks++;
            if (req_addr !== exp_addr) begin
                errors++;
                $display("FAIL %s/R3 req_addr got %0h exp %0h", tag, req_addr, exp_addr);
            end
            checks++;
            if (req_wdata !== 8'd1) begin
                errors++;
                $display("FAIL R2 req_wdata got %0d exp 1", req_wdata);
            end
        end
    endtask

    // called at a falling edge: drive, advance model, wait one cycle, compare
    task automatic cyc(input logic w, input logic av, input logic [1:0] ac,
                       input logic af, input string tag);
        req_wait = w;
        af_valid = av;
        af_chan  = ac;
        af_flag  = af;
        if (!(exp_wr && w)) begin
            if (mflags[mptr]) begin
                exp_wr = 1'b0;
            end else begin
                exp_wr   = 1'b1;
                exp_addr = {mptr, 2'b00};
            end
            mptr = mptr + 2'd1;
        end
        if (av) mflags[ac] = af;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [7:0] lf;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (req_wr !== 1'b0) begin
            errors++;
            $display("FAIL R1 req_wr in reset got %0b exp 0", req_wr);
        end
        checks++;
        if ($bits(req_addr) != 4) begin
            errors++;
            $display("FAIL R3 address width got %0d exp 4", $bits(req_addr));
        end
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, "R1");
        for (int i = 0; i < 2 * N; i++) cyc(0, 0, 0, 0, "R4");
        for (int i = 0; i < N + 1; i++) cyc(0, 0, 0, 0, "R5");
        // every mark pattern
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < N; c++) cyc(0, 1, 2'(c), m[c], "R8");
            for (int i = 0; i < 2 * N; i++) cyc(0, 0, 0, 0, "R6");
        end
        // clear all, then ignored updates with valid low
        for (int c = 0; c < N; c++) cyc(0, 1, 2'(c), 0, "R8");
        for (int i = 0; i < 3 * N; i++) cyc(0, 0, 2'(i), 1, "R8");
        // stalls with mixed marks
        lf = 8'h5a;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cyc(lf[0], lf[2] & lf[3], lf[5:4], lf[6] & lf[1], "R7");
        end
        for (int c = 0; c < N; c++) cyc(0, 1, 2'(c), 0, "R7");
        cyc(0, 0, 0, 0, "R7");
        for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, "R7");
        for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, "R7");
        // update aimed at the channel decided on the same edge
        for (int i = 0; i < 40; i++) cyc(0, 1, mptr, i[1], "R9");
        for (int i = 0; i < 40; i++) cyc(i[2], 1, mptr, ~i[0], "R9");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule